// File: doc/BRIEF.md
# Windowed Change Accumulator and Thresholder

This block makes the final per-pixel change decision of a ratio-based change detector. For every output pixel it receives nine 8-bit terms from a 3x3 neighbourhood, one set for each ratio direction. The forward ratio (previous over current frame) reveals change in dark regions and the inverse ratio reveals change in bright regions. Each set of nine terms is summed by an adder tree, and each sum is compared with a programmable 8-bit threshold scaled by the window size.

At the edges of the picture, four edge flags zero the neighbour lanes that fall outside the image, so the upstream logic can keep feeding its window unchanged. A two-bit mode picks which direction decides the result: forward, inverse, or either of the two. The decision is registered once, and a valid bit is delayed with it.

Top module: `wcd_change_accum`

## Requirements
- R1: Lane k of each term bus sits at bits 8k+7..8k, and lane k is the window position at row k/3 and column k%3 (row 0 is the top row, column 0 is the left column, lane 4 is the centre). The block adds every lane that is not masked.
- R2: When `edge_top` is high, lanes 0, 1 and 2 count as zero. When `edge_bot` is high, lanes 6, 7 and 8 count as zero. When `edge_lft` is high, lanes 0, 3 and 6 count as zero. When `edge_rgt` is high, lanes 2, 5 and 8 count as zero. This applies to both directions.
- R3: A direction reports a hit only when its sum is strictly greater than 9 times `thresh`. A sum equal to that limit is no hit.
- R4: `mode` 2'b01 uses the forward hit only. 2'b10 uses the inverse hit only. 2'b11 uses the OR of both hits. 2'b00 never reports a change.
- R5: `chg_valid` rises in the cycle after a clock edge that samples `in_valid` high. `chg_bit` then shows the decision for the inputs sampled at that edge. This holds for back-to-back pixels.
- R6: `chg_bit` is low whenever `chg_valid` is low, and inputs sampled with `in_valid` low produce no result.
- R7: While `rst_n` is low, `chg_valid` and `chg_bit` are low.
- R8: The sum never wraps. With all nine lanes at 255 (sum 2295), a threshold of 254 (limit 2286) gives a hit, and a threshold of 255 (limit 2295) gives none.
- R9: Edge flags combine. At a corner, with two adjacent flags high, five lanes are masked and only the other four are added.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | The terms and controls this cycle describe one pixel |
| mode | input | 2 | Direction select: 01 forward, 10 inverse, 11 both, 00 off |
| thresh | input | 8 | Unsigned threshold, scaled by 9 inside the block |
| edge_top | input | 1 | Pixel lies on the top image row |
| edge_bot | input | 1 | Pixel lies on the bottom image row |
| edge_lft | input | 1 | Pixel lies in the leftmost column |
| edge_rgt | input | 1 | Pixel lies in the rightmost column |
| fwd_terms | input | 72 | Nine forward-ratio terms, lane k at bits 8k+7..8k |
| inv_terms | input | 72 | Nine inverse-ratio terms, same layout |
| chg_valid | output | 1 | A decision is present on `chg_bit` |
| chg_bit | output | 1 | Change (1) or no change (0) |

## Verification
Masking, summing and comparison are combinational, and only the output register follows them. Each result therefore appears exactly one clock after the edge that samples its pixel. The bench drives each pixel on a falling edge and reads `chg_valid` and `chg_bit` one nanosecond after the next rising edge. Consecutive pixels are driven on successive falling edges, so streaming is checked pixel by pixel at that same one-cycle offset. Idle cycles are checked after one edge with `in_valid` low.

// File: rtl/wcd_pkg.sv
package wcd_pkg;

  localparam int WIN_DIM_D = 3;
  localparam int TERM_W_D  = 8;

  typedef enum logic [1:0] {
    MODE_NONE = 2'b00,
    MODE_FWD  = 2'b01,
    MODE_INV  = 2'b10,
    MODE_BOTH = 2'b11
  } det_mode_e;

  typedef struct packed {
    logic top;
    logic bot;
    logic lft;
    logic rgt;
  } edge_t;

  // True when a lane of a dim x dim window falls outside the image
  function automatic logic lane_outside(input int idx, input int dim, input edge_t e);
    int row;
    int col;
    row = idx / dim;
    col = idx % dim;
    return (e.top && row == 0) || (e.bot && row == dim - 1) ||
           (e.lft && col == 0) || (e.rgt && col == dim - 1);
  endfunction

  // Final verdict from the two direction hits under a mode
  function automatic logic merge_verdict(input det_mode_e m, input logic f_hit, input logic i_hit);
    logic v;
    case (m)
      MODE_FWD:  v = f_hit;
      MODE_INV:  v = i_hit;
      MODE_BOTH: v = f_hit | i_hit;
      default:   v = 1'b0;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/wcd_lane_mask.sv
module wcd_lane_mask #(
  parameter int WIN_DIM = wcd_pkg::WIN_DIM_D,
  parameter int TERM_W  = wcd_pkg::TERM_W_D,
  localparam int NTAP   = WIN_DIM * WIN_DIM
) (
  input  logic [NTAP*TERM_W-1:0] terms_flat,
  input  wcd_pkg::edge_t         edges,
  output logic [NTAP*TERM_W-1:0] masked_flat
);

  for (genvar k = 0; k < NTAP; k++) begin : g_lane
    logic kill;
    assign kill = wcd_pkg::lane_outside(k, WIN_DIM, edges);
    assign masked_flat[k*TERM_W +: TERM_W] = kill ? '0 : terms_flat[k*TERM_W +: TERM_W];
  end

endmodule

// File: rtl/wcd_adder_tree.sv
module wcd_adder_tree #(
  parameter int N     = 9,
  parameter int IN_W  = 8,
  parameter int OUT_W = 12,
  localparam int LVLS = $clog2(N),
  localparam int P    = 1 << LVLS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N*IN_W-1:0] in_flat,
  output logic [OUT_W-1:0]  sum
);

  localparam int MAX_SUM = N * ((1 << IN_W) - 1);

  for (genvar l = 0; l <= LVLS; l++) begin : lvl
    localparam int CNT = P >> l;
    logic [OUT_W-1:0] s [CNT];
    for (genvar i = 0; i < CNT; i++) begin : g_node
      if (l == 0) begin : g_leaf
        if (i < N) begin : g_real
          assign s[i] = OUT_W'(in_flat[i*IN_W +: IN_W]);
        end else begin : g_pad
          assign s[i] = '0;
        end
      end else begin : g_add
        assign s[i] = lvl[l-1].s[2*i] + lvl[l-1].s[2*i+1];
      end
    end
  end

  assign sum = lvl[LVLS].s[0];

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(sum) <= MAX_SUM);

endmodule

// File: rtl/wcd_thresh_cmp.sv
module wcd_thresh_cmp #(
  parameter int N     = 9,
  parameter int TH_W  = 8,
  parameter int SUM_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SUM_W-1:0] sum,
  input  logic [TH_W-1:0]  thresh,
  output logic             hit
);

  function automatic logic [SUM_W-1:0] scale_limit(input logic [TH_W-1:0] t);
    return SUM_W'(t) * SUM_W'(N);
  endfunction

  function automatic logic above_limit(input logic [SUM_W-1:0] s, input logic [SUM_W-1:0] lim);
    return s > lim;
  endfunction

  logic [SUM_W-1:0] limit;
  assign limit = scale_limit(thresh);
  assign hit   = above_limit(sum, limit);

  // R3
  equal_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sum == limit) |-> !hit);

endmodule

// File: rtl/wcd_change_accum.sv
module wcd_change_accum #(
  parameter int WIN_DIM = wcd_pkg::WIN_DIM_D,
  parameter int TERM_W  = wcd_pkg::TERM_W_D,
  localparam int NTAP   = WIN_DIM * WIN_DIM,
  localparam int SUM_W  = $clog2(NTAP * ((1 << TERM_W) - 1) + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [1:0]             mode,
  input  logic [TERM_W-1:0]      thresh,
  input  logic                   edge_top,
  input  logic                   edge_bot,
  input  logic                   edge_lft,
  input  logic                   edge_rgt,
  input  logic [NTAP*TERM_W-1:0] fwd_terms,
  input  logic [NTAP*TERM_W-1:0] inv_terms,
  output logic                   chg_valid,
  output logic                   chg_bit
);

  import wcd_pkg::*;

  edge_t                   edges;
  det_mode_e               mode_e;
  logic [NTAP*TERM_W-1:0]  fwd_masked;
  logic [NTAP*TERM_W-1:0]  inv_masked;
  logic [SUM_W-1:0]        fwd_sum;
  logic [SUM_W-1:0]        inv_sum;
  logic                    fwd_hit;
  logic                    inv_hit;
  logic                    verdict;

  assign edges  = '{top: edge_top, bot: edge_bot, lft: edge_lft, rgt: edge_rgt};
  assign mode_e = det_mode_e'(mode);

  wcd_lane_mask #(.WIN_DIM(WIN_DIM), .TERM_W(TERM_W)) u_fwd_mask (
    .terms_flat(fwd_terms), .edges(edges), .masked_flat(fwd_masked));
  wcd_lane_mask #(.WIN_DIM(WIN_DIM), .TERM_W(TERM_W)) u_inv_mask (
    .terms_flat(inv_terms), .edges(edges), .masked_flat(inv_masked));

  wcd_adder_tree #(.N(NTAP), .IN_W(TERM_W), .OUT_W(SUM_W)) u_fwd_tree (
    .clk(clk), .rst_n(rst_n), .in_flat(fwd_masked), .sum(fwd_sum));
  wcd_adder_tree #(.N(NTAP), .IN_W(TERM_W), .OUT_W(SUM_W)) u_inv_tree (
    .clk(clk), .rst_n(rst_n), .in_flat(inv_masked), .sum(inv_sum));

  wcd_thresh_cmp #(.N(NTAP), .TH_W(TERM_W), .SUM_W(SUM_W)) u_fwd_cmp (
    .clk(clk), .rst_n(rst_n), .sum(fwd_sum), .thresh(thresh), .hit(fwd_hit));
  wcd_thresh_cmp #(.N(NTAP), .TH_W(TERM_W), .SUM_W(SUM_W)) u_inv_cmp (
    .clk(clk), .rst_n(rst_n), .sum(inv_sum), .thresh(thresh), .hit(inv_hit));

  assign verdict = merge_verdict(mode_e, fwd_hit, inv_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chg_valid <= 1'b0;
      chg_bit   <= 1'b0;
    end else begin
      chg_valid <= in_valid;
      chg_bit   <= in_valid & verdict;
    end
  end

  // R5
  valid_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> chg_valid);

  // R6
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !chg_valid);

  // R6
  bit_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chg_valid |-> !chg_bit);

  // R4
  mode_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode_e == MODE_NONE) |=> !chg_bit);

  // R4
  fwd_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode_e == MODE_FWD) |=> (chg_bit == $past(fwd_hit)));

  // R4
  inv_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode_e == MODE_INV) |=> (chg_bit == $past(inv_hit)));

  // R2
  top_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edge_top |-> (fwd_masked[TERM_W-1:0] == '0 && inv_masked[TERM_W-1:0] == '0));

endmodule

// File: tb/tb_wcd_change_accum.sv
module tb_wcd_change_accum;

  localparam int NT = 9;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic [7:0]  thresh = 8'd0;
  logic        edge_top = 1'b0, edge_bot = 1'b0, edge_lft = 1'b0, edge_rgt = 1'b0;
  logic [71:0] fwd_terms = '0;
  logic [71:0] inv_terms = '0;
  logic        chg_valid;
  logic        chg_bit;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  wcd_change_accum dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode), .thresh(thresh),
    .edge_top(edge_top), .edge_bot(edge_bot), .edge_lft(edge_lft), .edge_rgt(edge_rgt),
    .fwd_terms(fwd_terms), .inv_terms(inv_terms),
    .chg_valid(chg_valid), .chg_bit(chg_bit));

  function automatic logic [71:0] all_lanes(input logic [7:0] v);
    logic [71:0] r;
    for (int k = 0; k < NT; k++) r[8*k +: 8] = v;
    return r;
  endfunction

  function automatic logic [71:0] one_lane(input int k, input logic [7:0] v);
    logic [71:0] r;
    r = '0;
    r[8*k +: 8] = v;
    return r;
  endfunction

  // Reference: walk the window by row and column, skip out-of-image cells
  function automatic int ref_sum(input logic [71:0] t, input logic [3:0] e);
    int acc;
    acc = 0;
    for (int r = 0; r < 3; r++)
      for (int c = 0; c < 3; c++) begin
        if (e[3] && r == 0) continue;
        if (e[2] && r == 2) continue;
        if (e[1] && c == 0) continue;
        if (e[0] && c == 2) continue;
        acc += int'(t[8*(3*r+c) +: 8]);
      end
    return acc;
  endfunction

  function automatic logic ref_bit(input logic [71:0] f, input logic [71:0] iv,
                                   input logic [3:0] e, input logic [1:0] m, input logic [7:0] th);
    logic fh, ih;
    fh = ref_sum(f, e) > 9 * int'(th);
    ih = ref_sum(iv, e) > 9 * int'(th);
    return (m[0] & fh) | (m[1] & ih);
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // e = {top, bot, lft, rgt}; result checked one cycle after sampling
  task automatic run_px(input logic [71:0] f, input logic [71:0] iv, input logic [3:0] e,
                        input logic [1:0] m, input logic [7:0] th, input string req);
    logic exp;
    exp = ref_bit(f, iv, e, m, th);
    @(negedge clk);
    fwd_terms = f; inv_terms = iv;
    {edge_top, edge_bot, edge_lft, edge_rgt} = e;
    mode = m; thresh = th; in_valid = 1'b1;
    @(posedge clk); #1;
    check({req, " valid"}, chg_valid, 1'b1);
    check({req, " bit"}, chg_bit, exp);
  endtask

  task automatic go_idle();
    @(negedge clk);
    in_valid = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    check("R7 valid in reset", chg_valid, 1'b0);
    check("R7 bit in reset", chg_bit, 1'b0);
  endtask

  task automatic t_threshold();
    // sum 90: limit 81 hit, limit 90 equal no hit
    run_px(all_lanes(8'd10), '0, 4'b0000, 2'b01, 8'd9, "R3 above");
    run_px(all_lanes(8'd10), '0, 4'b0000, 2'b01, 8'd10, "R3 equal");
    check("R3 equal explicit", chg_bit, 1'b0);
    go_idle();
  endtask

  task automatic t_lanes();
    for (int k = 0; k < NT; k++) begin
      run_px(one_lane(k, 8'd200), '0, 4'b0000, 2'b01, 8'd22, "R1 lane hit");
      check("R1 lane explicit", chg_bit, 1'b1);
      run_px(one_lane(k, 8'd198), '0, 4'b0000, 2'b01, 8'd22, "R1 lane edge");
    end
    go_idle();
  endtask

  task automatic t_edges();
    for (int f = 0; f < 4; f++)
      for (int k = 0; k < NT; k++) begin
        run_px(one_lane(k, 8'd255), one_lane(k, 8'd255), 4'(1 << f), 2'b11, 8'd0, "R2 single edge");
      end
    run_px(all_lanes(8'd30), '0, 4'b1000, 2'b01, 8'd20, "R2 top sum equal");
    run_px(all_lanes(8'd30), '0, 4'b1000, 2'b01, 8'd19, "R2 top sum above");
    go_idle();
  endtask

  task automatic t_corners();
    for (int c = 0; c < 4; c++) begin
      logic [3:0] e;
      e = (c == 0) ? 4'b1010 : (c == 1) ? 4'b1001 : (c == 2) ? 4'b0110 : 4'b0101;
      // four lanes of 40 survive: sum 160
      run_px(all_lanes(8'd40), '0, e, 2'b01, 8'd17, "R9 corner above");
      check("R9 corner explicit", chg_bit, 1'b1);
      run_px(all_lanes(8'd40), '0, e, 2'b01, 8'd18, "R9 corner below");
      check("R9 corner explicit low", chg_bit, 1'b0);
    end
    go_idle();
  endtask

  task automatic t_modes();
    for (int m = 0; m < 4; m++) begin
      run_px(all_lanes(8'd100), all_lanes(8'd5), 4'b0000, 2'(m), 8'd50, "R4 fwd strong");
      run_px(all_lanes(8'd5), all_lanes(8'd100), 4'b0000, 2'(m), 8'd50, "R4 inv strong");
    end
    run_px(all_lanes(8'd100), all_lanes(8'd100), 4'b0000, 2'b00, 8'd0, "R4 off");
    check("R4 off explicit", chg_bit, 1'b0);
    go_idle();
  endtask

  task automatic t_overflow();
    run_px(all_lanes(8'd255), all_lanes(8'd255), 4'b0000, 2'b11, 8'd254, "R8 full hit");
    check("R8 full hit explicit", chg_bit, 1'b1);
    run_px(all_lanes(8'd255), all_lanes(8'd255), 4'b0000, 2'b11, 8'd255, "R8 full equal");
    check("R8 full equal explicit", chg_bit, 1'b0);
    go_idle();
  endtask

  task automatic t_stream_idle();
    run_px(all_lanes(8'd90), '0, 4'b0000, 2'b01, 8'd10, "R5 stream a");
    run_px(all_lanes(8'd1), '0, 4'b0000, 2'b01, 8'd10, "R5 stream b");
    run_px(all_lanes(8'd90), '0, 4'b0000, 2'b01, 8'd10, "R5 stream c");
    @(negedge clk);
    in_valid = 1'b0;
    fwd_terms = all_lanes(8'd255); inv_terms = all_lanes(8'd255);
    mode = 2'b11; thresh = 8'd0;
    @(posedge clk); #1;
    check("R6 idle valid", chg_valid, 1'b0);
    check("R6 idle bit", chg_bit, 1'b0);
    @(posedge clk); #1;
    check("R6 idle hold", chg_bit, 1'b0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #1;
    t_reset();
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_threshold();
    t_lanes();
    t_edges();
    t_corners();
    t_modes();
    t_overflow();
    t_stream_idle();
    finish_run();
  end

  initial begin
    #(4 * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

endmodule